// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches host write cycles on a parallel NOR-style flash bus and decodes the multi-write unlock and command sequences that the host uses to control the array. Each write is presented for one clock on a synchronous strobe, together with an address and a 16-bit data word. The block tracks an operating mode: normal array read, identification (autoselect), unlock-bypass, erase running, erase suspended, or secured-sector access. The mode decides which sequences are accepted at any moment.

When a sequence completes, the block emits a one-clock command pulse. The pulse carries an opcode, the address and the data of the final write. For a program command, that final write holds the target address and the data word. For a sector erase, it holds the sector address. The array controller downstream acts on these pulses. Through `erase_busy` it tells the decoder when an erase has finished, and the decoder then returns to array read.

Top module: `flash_cmd_decoder`

## Requirements
- R1: During and after reset, `mode` is 0 (array read) and `cmd_valid` is 0, and no partial sequence is held.
- R2: In array read, the writes AA@555 and 55@2AA followed by 90@555 emit opcode 2 and enter mode 1 (autoselect). Mode 1 is left only by F0, and only to mode 0. Unlock sequences written in mode 1 emit nothing.
- R3: In array read or erase-suspended mode, an unlock pair followed by A0@555 arms a program. The next write of any kind emits opcode 4, with that write's full address and all 16 data bits, and the mode stays the same.
- R4: In array read, the six writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 emit opcode 5 (chip erase). The same five writes followed by 30 at any address emit opcode 6 (sector erase) with that address. Both enter mode 3 (erase running). Mode 3 returns to 0 one clock after `erase_busy` falls.
- R5: In mode 0 or 1, a write whose low data byte is F0, at any address, emits opcode 1 and sets mode 0. This also applies in the middle of a sequence, but not on the data write of a program.
- R6: A write of 98 at low address 0x0055 emits opcode 3 (CFI query) only in modes 0 and 1. In modes 2 and 5 it emits nothing and leaves the mode unchanged.
- R7: B0 at any address emits opcode 7 and enters mode 4 (suspended) only in mode 3 after a sector erase. After a chip erase it is ignored. 30 at any address emits opcode 8 and returns to mode 3 only from mode 4. B0 and 30 are ignored in other modes.
- R8: In mode 0, an unlock pair followed by 20@555 emits opcode 9 and enters mode 2 (bypass). In mode 2, A0 at any address followed by one more write emits opcode 4 for that write. 90 then 00, both at any address, emit opcode 10 and return to mode 0. F0 and unlock writes are ignored in mode 2.
- R9: In mode 0, an unlock pair followed by 88@555 emits opcode 11 and enters mode 5 (secured sector). In mode 5, the writes AA@555, 55@2AA, 90@555, then 00 at any address emit opcode 12 and return to mode 0.
- R10: For unlock and command writes, only data bits 7:0 and address bits 15:0 are compared. Data bits 15:8 and address bits at and above 16 do not change the decode.
- R11: A write that does not match the next expected write of a sequence discards the partial sequence, emits nothing and leaves the mode unchanged.
- R12: A command appears on `cmd_valid` for exactly the one clock after the accepting write. Opcodes are 0 none, 1 reset, 2 autoselect, 3 CFI, 4 program, 5 chip erase, 6 sector erase, 7 suspend, 8 resume, 9 bypass enter, 10 bypass exit, 11 secure enter, 12 secure exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One host write cycle is present this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data |
| erase_busy | input | 1 | High while the array is executing an erase |
| cmd_valid | output | 1 | One-clock pulse marking a decoded command |
| cmd_op | output | 4 | Opcode of the decoded command (see R12) |
| cmd_addr | output | ADDR_W | Address of the accepting write |
| cmd_data | output | 16 | Data of the accepting write |
| mode | output | 3 | Current mode: 0 read, 1 autoselect, 2 bypass, 3 erasing, 4 suspended, 5 secured |

## Verification
The bench builds the decoder with `ADDR_W` = 18, which leaves two address bits above the ignored boundary. These two bits, together with junk upper data bytes, are varied on every unlock and command write. The bench sweeps all 256 possible third-write command bytes after a valid unlock in array read mode, and works out for each byte the expected opcode, mode and recovery path. Directed passes then walk every mode through its legal and illegal writes, including the erase suspend and resume loop and the return to array read when `erase_busy` falls.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        MODE_READ    = 3'd0,
        MODE_AUTOSEL = 3'd1,
        MODE_BYPASS  = 3'd2,
        MODE_ERASING = 3'd3,
        MODE_SUSPEND = 3'd4,
        MODE_SECURE  = 3'd5
    } mode_e;

    typedef enum logic [3:0] {
        OP_NONE         = 4'd0,
        OP_RESET        = 4'd1,
        OP_AUTOSEL      = 4'd2,
        OP_CFI          = 4'd3,
        OP_PROGRAM      = 4'd4,
        OP_CHIP_ERASE   = 4'd5,
        OP_SECTOR_ERASE = 4'd6,
        OP_SUSPEND      = 4'd7,
        OP_RESUME       = 4'd8,
        OP_BYP_ENTER    = 4'd9,
        OP_BYP_EXIT     = 4'd10,
        OP_SEC_ENTER    = 4'd11,
        OP_SEC_EXIT     = 4'd12
    } op_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PROG,
        SQ_ERS3,
        SQ_ERS4,
        SQ_ERS5,
        SQ_BYP_PROG,
        SQ_BYP_EXIT,
        SQ_SEC_EXIT
    } seq_e;

    // classified view of one host write
    typedef struct packed {
        logic       at_555;
        logic       at_2aa;
        logic       at_055;
        logic [7:0] code;
    } cyc_t;

    localparam int          CMP_AW     = 16;
    localparam logic [15:0] ADR_UNLK_A = 16'h0555;
    localparam logic [15:0] ADR_UNLK_B = 16'h02AA;
    localparam logic [15:0] ADR_QUERY  = 16'h0055;

    localparam logic [7:0] B_UNLK_A  = 8'hAA;
    localparam logic [7:0] B_UNLK_B  = 8'h55;
    localparam logic [7:0] B_IDENT   = 8'h90;
    localparam logic [7:0] B_PROG    = 8'hA0;
    localparam logic [7:0] B_ERSETUP = 8'h80;
    localparam logic [7:0] B_BYPASS  = 8'h20;
    localparam logic [7:0] B_SECURE  = 8'h88;
    localparam logic [7:0] B_RESET   = 8'hF0;
    localparam logic [7:0] B_QUERY   = 8'h98;
    localparam logic [7:0] B_CHIP    = 8'h10;
    localparam logic [7:0] B_SECTOR  = 8'h30;
    localparam logic [7:0] B_SUSPEND = 8'hB0;
    localparam logic [7:0] B_RESUME  = 8'h30;
    localparam logic [7:0] B_EXIT    = 8'h00;

    // modes in which reset and query writes are honoured
    function automatic logic open_mode(mode_e m);
        return (m == MODE_READ) || (m == MODE_AUTOSEL);
    endfunction

    function automatic logic is_unlk_a(cyc_t c);
        return c.at_555 && (c.code == B_UNLK_A);
    endfunction

    function automatic logic is_unlk_b(cyc_t c);
        return c.at_2aa && (c.code == B_UNLK_B);
    endfunction

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
    import fcd_pkg::*;
(
    input  logic [CMP_AW-1:0] addr_lo,
    input  logic [7:0]        data_lo,
    output cyc_t              cyc
);
    always_comb begin
        cyc.at_555 = (addr_lo == ADR_UNLK_A);
        cyc.at_2aa = (addr_lo == ADR_UNLK_B);
        cyc.at_055 = (addr_lo == ADR_QUERY);
        cyc.code   = data_lo;
    end
endmodule

// File: rtl/fcd_fsm.sv
module fcd_fsm
    import fcd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stb,
    input  cyc_t  cyc,
    input  logic  erase_busy,
    output mode_e mode,
    output logic  emit,
    output op_e   op
);
    seq_e  seq, seq_n;
    mode_e mode_n;
    logic  sect_q, sect_n;
    logic  busy_q;
    logic  erase_done;

    assign erase_done = (mode == MODE_ERASING) && busy_q && !erase_busy;

    always_comb begin
        seq_n  = seq;
        mode_n = mode;
        sect_n = sect_q;
        emit   = 1'b0;
        op     = OP_NONE;
        if (stb) begin
            seq_n = SQ_IDLE;
            if (cyc.code == B_RESET && open_mode(mode) && seq != SQ_PROG) begin
                emit   = 1'b1;
                op     = OP_RESET;
                mode_n = MODE_READ;
            end else begin
                case (seq)
                    SQ_IDLE: begin
                        case (mode)
                            MODE_READ: begin
                                if (cyc.at_055 && cyc.code == B_QUERY) begin
                                    emit = 1'b1;
                                    op   = OP_CFI;
                                end else if (is_unlk_a(cyc)) begin
                                    seq_n = SQ_UNL1;
                                end
                            end
                            MODE_AUTOSEL: begin
                                if (cyc.at_055 && cyc.code == B_QUERY) begin
                                    emit = 1'b1;
                                    op   = OP_CFI;
                                end
                            end
                            MODE_BYPASS: begin
                                if (cyc.code == B_PROG)
                                    seq_n = SQ_BYP_PROG;
                                else if (cyc.code == B_IDENT)
                                    seq_n = SQ_BYP_EXIT;
                            end
                            MODE_ERASING: begin
                                if (cyc.code == B_SUSPEND && sect_q) begin
                                    emit   = 1'b1;
                                    op     = OP_SUSPEND;
                                    mode_n = MODE_SUSPEND;
                                end
                            end
                            MODE_SUSPEND: begin
                                if (cyc.code == B_RESUME) begin
                                    emit   = 1'b1;
                                    op     = OP_RESUME;
                                    mode_n = MODE_ERASING;
                                end else if (is_unlk_a(cyc)) begin
                                    seq_n = SQ_UNL1;
                                end
                            end
                            MODE_SECURE: begin
                                if (is_unlk_a(cyc))
                                    seq_n = SQ_UNL1;
                            end
                            default: ;
                        endcase
                    end
                    SQ_UNL1: begin
                        if (is_unlk_b(cyc))
                            seq_n = SQ_UNL2;
                    end
                    SQ_UNL2: begin
                        if (cyc.at_555) begin
                            if (mode == MODE_READ) begin
                                case (cyc.code)
                                    B_IDENT: begin
                                        emit   = 1'b1;
                                        op     = OP_AUTOSEL;
                                        mode_n = MODE_AUTOSEL;
                                    end
                                    B_PROG:    seq_n = SQ_PROG;
                                    B_ERSETUP: seq_n = SQ_ERS3;
                                    B_BYPASS: begin
                                        emit   = 1'b1;
                                        op     = OP_BYP_ENTER;
                                        mode_n = MODE_BYPASS;
                                    end
                                    B_SECURE: begin
                                        emit   = 1'b1;
                                        op     = OP_SEC_ENTER;
                                        mode_n = MODE_SECURE;
                                    end
                                    default: ;
                                endcase
                            end else if (mode == MODE_SUSPEND) begin
                                if (cyc.code == B_PROG)
                                    seq_n = SQ_PROG;
                            end else if (mode == MODE_SECURE) begin
                                if (cyc.code == B_IDENT)
                                    seq_n = SQ_SEC_EXIT;
                            end
                        end
                    end
                    SQ_PROG, SQ_BYP_PROG: begin
                        emit = 1'b1;
                        op   = OP_PROGRAM;
                    end
                    SQ_ERS3: begin
                        if (is_unlk_a(cyc))
                            seq_n = SQ_ERS4;
                    end
                    SQ_ERS4: begin
                        if (is_unlk_b(cyc))
                            seq_n = SQ_ERS5;
                    end
                    SQ_ERS5: begin
                        if (cyc.at_555 && cyc.code == B_CHIP) begin
                            emit   = 1'b1;
                            op     = OP_CHIP_ERASE;
                            mode_n = MODE_ERASING;
                            sect_n = 1'b0;
                        end else if (cyc.code == B_SECTOR) begin
                            emit   = 1'b1;
                            op     = OP_SECTOR_ERASE;
                            mode_n = MODE_ERASING;
                            sect_n = 1'b1;
                        end
                    end
                    SQ_BYP_EXIT: begin
                        if (cyc.code == B_EXIT) begin
                            emit   = 1'b1;
                            op     = OP_BYP_EXIT;
                            mode_n = MODE_READ;
                        end
                    end
                    SQ_SEC_EXIT: begin
                        if (cyc.code == B_EXIT) begin
                            emit   = 1'b1;
                            op     = OP_SEC_EXIT;
                            mode_n = MODE_READ;
                        end
                    end
                    default: ;
                endcase
            end
        end
        if (erase_done)
            mode_n = MODE_READ;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq    <= SQ_IDLE;
            mode   <= MODE_READ;
            sect_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            seq    <= seq_n;
            mode   <= mode_n;
            sect_q <= sect_n;
            busy_q <= erase_busy;
        end
    end

    // R7
    suspend_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SUSPEND && $past(mode) != MODE_SUSPEND) |-> $past(mode) == MODE_ERASING);

    // R2
    autosel_exit_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == MODE_AUTOSEL && mode != MODE_AUTOSEL) |-> mode == MODE_READ);

    // R8
    bypass_exit_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == MODE_BYPASS && mode != MODE_BYPASS) |-> mode == MODE_READ);

    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(stb) && !$past(erase_done)) |-> mode == $past(mode));

    // R4
    erase_return_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == MODE_ERASING && mode == MODE_READ) |-> $fell(busy_q));

endmodule

// File: rtl/fcd_out_reg.sv
module fcd_out_reg
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              emit,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       data,
    output logic              cmd_valid,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [15:0]       cmd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            cmd_op    <= OP_NONE;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= emit;
            if (emit) begin
                cmd_op   <= op;
                cmd_addr <= addr;
                cmd_data <= data;
            end
        end
    end

    // R12
    valid_op_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd_op != OP_NONE);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              erase_busy,
    output logic              cmd_valid,
    output logic [3:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [15:0]       cmd_data,
    output logic [2:0]        mode
);
    cyc_t  cyc;
    mode_e mode_s;
    logic  emit;
    op_e   op;
    op_e   op_q;

    fcd_classify u_classify (
        .addr_lo (wr_addr[CMP_AW-1:0]),
        .data_lo (wr_data[7:0]),
        .cyc     (cyc)
    );

    fcd_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .stb        (wr_stb),
        .cyc        (cyc),
        .erase_busy (erase_busy),
        .mode       (mode_s),
        .emit       (emit),
        .op         (op)
    );

    fcd_out_reg #(.ADDR_W(ADDR_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .emit      (emit),
        .op        (op),
        .addr      (wr_addr),
        .data      (wr_data),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_q),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data)
    );

    assign cmd_op = op_q;
    assign mode   = mode_s;

    // R12
    pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(wr_stb));

    // R3
    prog_data_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_PROGRAM) |-> cmd_data == $past(wr_data));
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    import fcd_pkg::*;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic          erase_busy = 1'b0;
    logic          cmd_valid;
    logic [3:0]    cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [15:0]   cmd_data;
    logic [2:0]    mode;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic          g_v;
    logic [3:0]    g_op;
    logic [AW-1:0] g_a;
    logic [15:0]   g_d;
    logic [2:0]    g_m;

    always #5 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .erase_busy (erase_busy),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data),
        .mode       (mode)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got=%0h exp=%0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        g_v  = cmd_valid;
        g_op = cmd_op;
        g_a  = cmd_addr;
        g_d  = cmd_data;
        g_m  = mode;
        wr_stb = 1'b0;
    endtask

    task automatic expect_cmd(input string req, input logic v, input op_e op, input int m);
        chk(req, "valid", int'(g_v), int'(v));
        if (v) chk(req, "op", int'(g_op), int'(op));
        chk(req, "mode", int'(g_m), m);
    endtask

    task automatic expect_ad(input string req, input logic [AW-1:0] a, input logic [15:0] d);
        chk(req, "addr", int'(g_a), int'(a));
        chk(req, "data", int'(g_d), int'(d));
    endtask

    // unlock pair with junk in ignored bits (R10)
    task automatic unlock(input string req, input logic [1:0] hi, input logic [7:0] junk, input int m);
        wr({hi, 16'h0555}, {junk, 8'hAA});
        expect_cmd(req, 1'b0, OP_NONE, m);
        wr({~hi, 16'h02AA}, {~junk, 8'h55});
        expect_cmd(req, 1'b0, OP_NONE, m);
    endtask

    task automatic idle_check(input string req);
        @(posedge clk);
        #1;
        chk(req, "pulse_width", int'(cmd_valid), 0);
    endtask

    task automatic erase_prefix(input logic [1:0] hi);
        unlock("R4", hi, 8'h13, 0);
        wr({hi, 16'h0555}, 16'h4480);
        expect_cmd("R4", 1'b0, OP_NONE, 0);
        unlock("R4", ~hi, 8'h77, 0);
    endtask

    task automatic sweep_third();
        for (int b = 0; b < 256; b++) begin
            logic [7:0]    c;
            logic [1:0]    hi;
            logic [AW-1:0] pa;
            logic [15:0]   pd;
            c  = b[7:0];
            hi = c[1:0];
            unlock("R10", hi, ~c, 0);
            wr({~hi, 16'h0555}, {c ^ 8'h5A, c});
            if (c == 8'h90) begin
                expect_cmd("R2", 1'b1, OP_AUTOSEL, 1);
                wr({hi, 16'h1234}, {c, 8'hF0});
                expect_cmd("R5", 1'b1, OP_RESET, 0);
            end else if (c == 8'hA0) begin
                expect_cmd("R3", 1'b0, OP_NONE, 0);
                pa = {hi, c, 8'h3C};
                pd = 16'hC3A5 ^ {c, c};
                wr(pa, pd);
                expect_cmd("R3", 1'b1, OP_PROGRAM, 0);
                expect_ad("R3", pa, pd);
            end else if (c == 8'h80) begin
                expect_cmd("R4", 1'b0, OP_NONE, 0);
                wr('0, 16'h0000);
                expect_cmd("R11", 1'b0, OP_NONE, 0);
            end else if (c == 8'h20) begin
                expect_cmd("R8", 1'b1, OP_BYP_ENTER, 2);
                wr({hi, 16'h0777}, 16'h3390);
                expect_cmd("R8", 1'b0, OP_NONE, 2);
                wr({hi, 16'h0123}, 16'h9900);
                expect_cmd("R8", 1'b1, OP_BYP_EXIT, 0);
            end else if (c == 8'h88) begin
                expect_cmd("R9", 1'b1, OP_SEC_ENTER, 5);
                unlock("R9", hi, c, 5);
                wr({hi, 16'h0555}, 16'h0190);
                expect_cmd("R9", 1'b0, OP_NONE, 5);
                wr({hi, 16'h4321}, 16'hAB00);
                expect_cmd("R9", 1'b1, OP_SEC_EXIT, 0);
            end else if (c == 8'hF0) begin
                expect_cmd("R5", 1'b1, OP_RESET, 0);
            end else begin
                expect_cmd("R11", 1'b0, OP_NONE, 0);
            end
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "mode", int'(mode), 0);
        chk("R1", "valid", int'(cmd_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", "mode_after", int'(mode), 0);

        // R10 R2 R3 R5 R8 R9 R11: all third-write command bytes
        sweep_third();

        // R6 query in each mode
        wr(18'h3_0055, 16'h7798);
        expect_cmd("R6", 1'b1, OP_CFI, 0);
        idle_check("R12");
        wr(18'h0_0056, 16'h0098);
        expect_cmd("R6", 1'b0, OP_NONE, 0);
        unlock("R6", 2'b00, 8'h00, 0);
        wr(18'h0_0555, 16'h0090);
        expect_cmd("R2", 1'b1, OP_AUTOSEL, 1);
        wr(18'h1_0055, 16'h0098);
        expect_cmd("R6", 1'b1, OP_CFI, 1);
        unlock("R2", 2'b00, 8'h00, 1);
        wr(18'h0_0555, 16'h00A0);
        expect_cmd("R2", 1'b0, OP_NONE, 1);
        wr(18'h0_0100, 16'h1234);
        expect_cmd("R2", 1'b0, OP_NONE, 1);
        wr(18'h2_0000, 16'h55F0);
        expect_cmd("R5", 1'b1, OP_RESET, 0);
        unlock("R6", 2'b01, 8'h00, 0);
        wr(18'h0_0555, 16'h0020);
        expect_cmd("R8", 1'b1, OP_BYP_ENTER, 2);
        wr(18'h0_0055, 16'h0098);
        expect_cmd("R6", 1'b0, OP_NONE, 2);
        wr(18'h0_0000, 16'h00F0);
        expect_cmd("R8", 1'b0, OP_NONE, 2);
        wr(18'h0_0555, 16'h00AA);
        expect_cmd("R8", 1'b0, OP_NONE, 2);
        // R8 bypass program
        wr(18'h3_FFFF, 16'h00A0);
        expect_cmd("R8", 1'b0, OP_NONE, 2);
        wr(18'h2_ABCD, 16'hBEEF);
        expect_cmd("R8", 1'b1, OP_PROGRAM, 2);
        expect_ad("R8", 18'h2_ABCD, 16'hBEEF);
        idle_check("R12");
        wr(18'h0_0000, 16'h0090);
        wr(18'h0_0000, 16'h0000);
        expect_cmd("R8", 1'b1, OP_BYP_EXIT, 0);
        unlock("R6", 2'b10, 8'h00, 0);
        wr(18'h0_0555, 16'h0088);
        expect_cmd("R9", 1'b1, OP_SEC_ENTER, 5);
        wr(18'h0_0055, 16'h0098);
        expect_cmd("R6", 1'b0, OP_NONE, 5);
        wr(18'h0_0000, 16'h00F0);
        expect_cmd("R9", 1'b0, OP_NONE, 5);
        unlock("R9", 2'b00, 8'h00, 5);
        wr(18'h0_0555, 16'h0090);
        wr(18'h0_0000, 16'h0000);
        expect_cmd("R9", 1'b1, OP_SEC_EXIT, 0);

        // R7 suspend/resume ignored outside their modes
        wr(18'h0_0000, 16'h00B0);
        expect_cmd("R7", 1'b0, OP_NONE, 0);
        wr(18'h0_0000, 16'h0030);
        expect_cmd("R7", 1'b0, OP_NONE, 0);

        // R4 chip erase, not suspendable
        erase_prefix(2'b01);
        wr(18'h3_0555, 16'hFF10);
        expect_cmd("R4", 1'b1, OP_CHIP_ERASE, 3);
        expect_ad("R4", 18'h3_0555, 16'hFF10);
        @(negedge clk);
        erase_busy = 1'b1;
        repeat (2) @(posedge clk);
        wr(18'h0_0000, 16'h00B0);
        expect_cmd("R7", 1'b0, OP_NONE, 3);
        @(negedge clk);
        erase_busy = 1'b0;
        @(posedge clk);
        #1;
        chk("R4", "mode_done", int'(mode), 0);

        // R4 sector erase, then R7 suspend loop
        erase_prefix(2'b10);
        wr(18'h2_7000, 16'h0030);
        expect_cmd("R4", 1'b1, OP_SECTOR_ERASE, 3);
        expect_ad("R4", 18'h2_7000, 16'h0030);
        @(negedge clk);
        erase_busy = 1'b1;
        wr(18'h0_0000, 16'h0030);
        expect_cmd("R7", 1'b0, OP_NONE, 3);
        wr(18'h0_0000, 16'h00F0);
        expect_cmd("R5", 1'b0, OP_NONE, 3);
        wr(18'h1_2345, 16'hCCB0);
        expect_cmd("R7", 1'b1, OP_SUSPEND, 4);
        wr(18'h0_0000, 16'h00F0);
        expect_cmd("R7", 1'b0, OP_NONE, 4);
        unlock("R3", 2'b11, 8'h21, 4);
        wr(18'h0_0555, 16'h00A0);
        expect_cmd("R3", 1'b0, OP_NONE, 4);
        wr(18'h1_0F0F, 16'h00F0);
        expect_cmd("R3", 1'b1, OP_PROGRAM, 4);
        expect_ad("R3", 18'h1_0F0F, 16'h00F0);
        wr(18'h0_0000, 16'h0030);
        expect_cmd("R7", 1'b1, OP_RESUME, 3);
        @(negedge clk);
        erase_busy = 1'b0;
        @(posedge clk);
        #1;
        chk("R4", "mode_done", int'(mode), 0);

        // R11 broken sequences
        wr(18'h0_0555, 16'h00AA);
        wr(18'h0_02AA, 16'h0054);
        expect_cmd("R11", 1'b0, OP_NONE, 0);
        wr(18'h0_0555, 16'h0090);
        expect_cmd("R11", 1'b0, OP_NONE, 0);
        erase_prefix(2'b00);
        wr(18'h0_0556, 16'h0010);
        expect_cmd("R11", 1'b0, OP_NONE, 0);
        wr(18'h0_0555, 16'h0010);
        expect_cmd("R11", 1'b0, OP_NONE, 0);
        unlock("R11", 2'b00, 8'h00, 0);
        wr(18'h0_0554, 16'h0090);
        expect_cmd("R11", 1'b0, OP_NONE, 0);
        idle_check("R12");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule